// File: doc/BRIEF.md
# Packed signed word minimum unit

This block is a SIMD datapath that forms the lane-by-lane minimum of two packed vectors of 16-bit two's-complement integers. A two-bit form selector picks how many lanes take part: four lanes, eight lanes in a read-modify-write form, eight lanes in a three-operand form, or all sixteen lanes. The selector also decides where the first operand comes from and what the result holds above the active width.

In the two read-modify-write forms the first operand is the old destination vector, and result bits above the active width keep the old destination value. In the three-operand forms the first operand is a separate source, the destination is write-only, and in the eight-lane case bits above the active width are cleared. The result is registered and appears one clock after the input strobe, with a matching valid flag.

Top module: `psmin_unit`

## Requirements
- R1: Every lane is compared as a signed 16-bit value, so 16'h8000 (-32768) is below 16'h7FFF and 16'hFFFF (-1) is below 16'h0000.
- R2: A result lane takes the first operand's lane only when it is strictly less than the second operand's lane; otherwise, equality included, it takes the second operand's lane.
- R3: With mode 2'b00, lanes 0..3 (bits 63:0) hold the minimum and bits 255:64 equal dest_old[255:64].
- R4: With mode 2'b01, lanes 0..7 (bits 127:0) hold the minimum and bits 255:128 equal dest_old[255:128].
- R5: With mode 2'b10, lanes 0..7 hold the minimum and bits 255:128 are zero.
- R6: With mode 2'b11, all sixteen lanes (bits 255:0) hold the minimum.
- R7: In modes 2'b00 and 2'b01 the first operand is dest_old; src_a has no effect on the result.
- R8: In modes 2'b10 and 2'b11 the first operand is src_a and dest_old has no effect on the result.
- R9: result and out_valid change one clock after an input strobe: out_valid is high in the cycle after in_valid was high and low otherwise.
- R10: When in_valid is low, result keeps its previous value.
- R11: While rst_n is low, out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input strobe; loads a new result |
| mode | input | 2 | Form selector: 00 four lanes keep, 01 eight lanes keep, 10 eight lanes clear, 11 sixteen lanes |
| src_a | input | 256 | First operand in the three-operand forms |
| src_b | input | 256 | Second operand in every form |
| dest_old | input | 256 | Previous destination value |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| result | output | 256 | Registered packed result |

## Verification
Every form is driven with random vectors whose lanes are often made equal or sign-flipped, which separates a signed compare from an unsigned one and a strict from a non-strict choice. Directed vectors put 16'h8000 against 16'h7FFF and 16'hFFFF against 16'h0000 in both operand orders, exposing a compare that ignores the sign bit. Each form is repeated with src_a or dest_old changed alone, so a wrong operand source or a wrong upper-bit rule (kept versus cleared, and the 64- versus 128-bit boundary) shows up as a mismatch. A cycle with the strobe low and all inputs changed shows whether the result holds.

// File: rtl/psmin_pkg.sv
package psmin_pkg;
  typedef enum logic [1:0] {
    FORM_Q4_KEEP  = 2'b00,
    FORM_H8_KEEP  = 2'b01,
    FORM_H8_CLEAR = 2'b10,
    FORM_F16      = 2'b11
  } psmin_form_e;
endpackage

// File: rtl/psmin_mode_dec.sv
module psmin_mode_dec #(
  parameter int unsigned LANES = 16
) (
  input  logic [1:0]       mode,
  output logic [LANES-1:0] lane_act,
  output logic             first_from_old,
  output logic             keep_upper
);
  import psmin_pkg::*;

  localparam int unsigned QTR  = LANES / 4;
  localparam int unsigned HALF = LANES / 2;

  int unsigned n_act;

  always_comb begin
    n_act          = LANES;
    first_from_old = 1'b0;
    keep_upper     = 1'b0;
    case (psmin_form_e'(mode))
      FORM_Q4_KEEP: begin
        n_act          = QTR;
        first_from_old = 1'b1;
        keep_upper     = 1'b1;
      end
      FORM_H8_KEEP: begin
        n_act          = HALF;
        first_from_old = 1'b1;
        keep_upper     = 1'b1;
      end
      FORM_H8_CLEAR: begin
        n_act = HALF;
      end
      default: begin
        n_act = LANES;
      end
    endcase
    for (int i = 0; i < LANES; i++) begin
      lane_act[i] = (i < n_act);
    end
  end
endmodule

// File: rtl/psmin_lane.sv
module psmin_lane #(
  parameter int unsigned LANE_W = 16
) (
  input  logic [LANE_W-1:0] op_first,
  input  logic [LANE_W-1:0] op_second,
  input  logic [LANE_W-1:0] old_val,
  input  logic              active,
  input  logic              keep,
  output logic [LANE_W-1:0] lane_out
);
  logic              first_lt;
  logic [LANE_W-1:0] smaller;

  always_comb begin
    first_lt = ($signed(op_first) < $signed(op_second));
    smaller  = first_lt ? op_first : op_second;
    if (active) begin
      lane_out = smaller;
    end else if (keep) begin
      lane_out = old_val;
    end else begin
      lane_out = '0;
    end
  end
endmodule

// File: rtl/psmin_unit.sv
module psmin_unit #(
  parameter int unsigned LANE_W = 16,
  parameter int unsigned LANES  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [1:0]              mode,
  input  logic [LANE_W*LANES-1:0] src_a,
  input  logic [LANE_W*LANES-1:0] src_b,
  input  logic [LANE_W*LANES-1:0] dest_old,
  output logic                    out_valid,
  output logic [LANE_W*LANES-1:0] result
);
  localparam int unsigned VEC_W = LANE_W * LANES;

  logic [LANES-1:0] lane_act;
  logic             first_from_old;
  logic             keep_upper;
  logic [VEC_W-1:0] first_vec;
  logic [VEC_W-1:0] lane_res;
  logic [VEC_W-1:0] res_d;
  logic [VEC_W-1:0] res_q;
  logic             vld_d;
  logic             vld_q;

  psmin_mode_dec #(.LANES(LANES)) u_dec (
    .mode           (mode),
    .lane_act       (lane_act),
    .first_from_old (first_from_old),
    .keep_upper     (keep_upper)
  );

  assign first_vec = first_from_old ? dest_old : src_a;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    psmin_lane #(.LANE_W(LANE_W)) u_lane (
      .op_first  (first_vec[g*LANE_W +: LANE_W]),
      .op_second (src_b[g*LANE_W +: LANE_W]),
      .old_val   (dest_old[g*LANE_W +: LANE_W]),
      .active    (lane_act[g]),
      .keep      (keep_upper),
      .lane_out  (lane_res[g*LANE_W +: LANE_W])
    );
  end

  // next state
  always_comb begin
    vld_d = in_valid;
    res_d = res_q;
    if (in_valid) begin
      res_d = lane_res;
    end
  end

  // control register, reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
    end
  end

  // datapath register, clock enable only
  always_ff @(posedge clk) begin
    if (in_valid) begin
      res_q <= res_d;
    end
  end

  assign out_valid = vld_q;
  assign result    = res_q;
endmodule

// File: rtl/psmin_unit_chk.sv
module psmin_unit_chk #(
  parameter int unsigned LANE_W = 16,
  parameter int unsigned LANES  = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic [1:0]              mode,
  input logic [LANE_W*LANES-1:0] src_a,
  input logic [LANE_W*LANES-1:0] src_b,
  input logic [LANE_W*LANES-1:0] dest_old,
  input logic                    out_valid,
  input logic [LANE_W*LANES-1:0] result
);
  localparam int unsigned VEC_W = LANE_W * LANES;
  localparam int unsigned QW    = VEC_W / 4;
  localparam int unsigned HW    = VEC_W / 2;

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_clears_valid_r11: assert (!out_valid);
    end
  end

  p_valid_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_no_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_hold_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));

  p_keep_upper_q_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'b00) |=> result[VEC_W-1:QW] == $past(dest_old[VEC_W-1:QW]));

  p_keep_upper_h_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'b01) |=> result[VEC_W-1:HW] == $past(dest_old[VEC_W-1:HW]));

  p_clear_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'b10) |=> result[VEC_W-1:HW] == '0);

  for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
    p_full_min_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mode == 2'b11) |=>
        ($signed(result[g*LANE_W +: LANE_W]) <= $signed($past(src_a[g*LANE_W +: LANE_W])) &&
         $signed(result[g*LANE_W +: LANE_W]) <= $signed($past(src_b[g*LANE_W +: LANE_W])) &&
         (result[g*LANE_W +: LANE_W] == $past(src_a[g*LANE_W +: LANE_W]) ||
          result[g*LANE_W +: LANE_W] == $past(src_b[g*LANE_W +: LANE_W]))));
  end
endmodule

bind psmin_unit psmin_unit_chk #(.LANE_W(LANE_W), .LANES(LANES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .mode      (mode),
  .src_a     (src_a),
  .src_b     (src_b),
  .dest_old  (dest_old),
  .out_valid (out_valid),
  .result    (result)
);

// File: tb/psmin_unit_bench.sv
module psmin_unit_bench;
  localparam int unsigned VW = 256;

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic [1:0]    mode;
  logic [VW-1:0] src_a;
  logic [VW-1:0] src_b;
  logic [VW-1:0] dest_old;
  logic          out_valid;
  logic [VW-1:0] result;

  int n_checks;
  int n_fails;
  bit done;

  psmin_unit u_psmin_unit (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .mode      (mode),
    .src_a     (src_a),
    .src_b     (src_b),
    .dest_old  (dest_old),
    .out_valid (out_valid),
    .result    (result)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // bench model: signed order via offset-binary unsigned compare
  function automatic logic [VW-1:0] model(input logic [1:0] m, input logic [VW-1:0] a,
                                          input logic [VW-1:0] b, input logic [VW-1:0] d);
    logic [VW-1:0] r;
    int n;
    n = (m == 2'b00) ? 4 : (m == 2'b11) ? 16 : 8;
    for (int i = 0; i < 16; i++) begin
      logic [15:0] x;
      logic [15:0] y;
      x = m[1] ? a[i*16 +: 16] : d[i*16 +: 16];
      y = b[i*16 +: 16];
      if (i < n) r[i*16 +: 16] = ((x ^ 16'h8000) < (y ^ 16'h8000)) ? x : y;
      else if (m == 2'b10) r[i*16 +: 16] = 16'h0000;
      else r[i*16 +: 16] = d[i*16 +: 16];
    end
    return r;
  endfunction

  function automatic logic [VW-1:0] rnd_vec();
    logic [VW-1:0] v;
    for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic check_bit(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic check_vec(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // drive at negedge, result registered at next posedge, sample at following negedge
  task automatic apply(input string tag, input logic [1:0] m, input logic [VW-1:0] a,
                       input logic [VW-1:0] b, input logic [VW-1:0] d);
    in_valid = 1'b1;
    mode     = m;
    src_a    = a;
    src_b    = b;
    dest_old = d;
    @(negedge clk);
    check_vec(tag, result, model(m, a, b, d));
    check_bit({tag, " R9 valid"}, out_valid, 1'b1);
  endtask

  initial begin
    logic [VW-1:0] a, b, d, ca, cb, held;
    void'($urandom(32'h5EED_0017));
    n_checks = 0;
    n_fails  = 0;
    done     = 1'b0;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    mode     = 2'b00;
    src_a    = '0;
    src_b    = '0;
    dest_old = '0;
    repeat (3) @(negedge clk);
    check_bit("R11 reset valid low", out_valid, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check_bit("R9 idle valid low", out_valid, 1'b0);

    // signed corner cases, both operand orders, every mode
    for (int m = 0; m < 4; m++) begin
      for (int i = 0; i < 16; i++) begin
        case (i % 4)
          0: begin ca[i*16 +: 16] = 16'h8000; cb[i*16 +: 16] = 16'h7FFF; end
          1: begin ca[i*16 +: 16] = 16'h7FFF; cb[i*16 +: 16] = 16'h8000; end
          2: begin ca[i*16 +: 16] = 16'hFFFF; cb[i*16 +: 16] = 16'h0000; end
          default: begin ca[i*16 +: 16] = 16'h0000; cb[i*16 +: 16] = 16'hFFFF; end
        endcase
      end
      apply("R1 corners first=a", 2'(m), ca, cb, ca);
      apply("R1 corners first=b", 2'(m), cb, ca, cb);
      apply("R2 equal lanes", 2'(m), ca, ca, ca);
    end

    // upper-bit rules and operand source, each mode
    for (int k = 0; k < 10; k++) begin
      a = rnd_vec(); b = rnd_vec(); d = rnd_vec();
      apply("R3 four-lane keep", 2'b00, a, b, d);
      apply("R7 src_a ignored mode00", 2'b00, ~a, b, d);
      apply("R4 eight-lane keep", 2'b01, a, b, d);
      apply("R7 src_a ignored mode01", 2'b01, ~a, b, d);
      apply("R5 eight-lane clear", 2'b10, a, b, d);
      apply("R8 dest_old ignored mode10", 2'b10, a, b, ~d);
      apply("R6 sixteen lanes", 2'b11, a, b, d);
      apply("R8 dest_old ignored mode11", 2'b11, a, b, ~d);
    end

    // random with biased lanes: equal, sign-flipped, raw
    for (int k = 0; k < 400; k++) begin
      a = rnd_vec(); b = rnd_vec(); d = rnd_vec();
      for (int i = 0; i < 16; i++) begin
        case ($urandom % 4)
          0: b[i*16 +: 16] = a[i*16 +: 16];
          1: b[i*16 +: 16] = a[i*16 +: 16] ^ 16'h8000;
          2: d[i*16 +: 16] = b[i*16 +: 16];
          default: ;
        endcase
      end
      apply("R1 R2 random", 2'($urandom % 4), a, b, d);
    end

    // hold with strobe low
    held     = result;
    in_valid = 1'b0;
    mode     = 2'b11;
    src_a    = rnd_vec();
    src_b    = rnd_vec();
    dest_old = rnd_vec();
    @(negedge clk);
    check_vec("R10 hold result", result, held);
    check_bit("R9 valid drops", out_valid, 1'b0);
    @(negedge clk);
    check_vec("R10 hold second cycle", result, held);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule